// File: doc/BRIEF.md
# Multicycle Processor Main Control Sequencer

This block is the main controller of a multicycle 32-bit load/store datapath. Each instruction runs as a walk through a short chain of states. Each state takes one clock cycle. The first two states are common to every instruction: a fetch state and a decode state. The decode state branches on the 6-bit operation field held in the instruction register. For operation 0, it also branches on the 6-bit function field, which separates a register-indirect jump from ordinary register-to-register arithmetic. Every datapath control line is decoded from the current state alone. Inputs never reach the outputs within the same cycle.

The instruction set served is:

- word load
- word store
- register arithmetic
- branch-if-equal
- absolute jump
- register-indirect jump

The register-indirect jump has its own completion state. That state loads the program counter from the register value through the fourth input of the PC-source selector. The datapath, the ALU and its function decoder, and the memories sit outside. They read the control lines and provide the two instruction fields.

Top module: `multicycle_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the block in the fetch state. This holds while `rst` is high and also when `rst` is raised in the middle of an instruction. The fetch state drives `mem_rd_en`=1, `ir_load`=1, `pc_load`=1, `alu_b_sel`=01 and `pc_src`=00. All other outputs are 0 in fetch, including `mem_addr_sel`, `alu_a_sel` and `alu_mode`.
- R2: The cycle after fetch is always decode. Decode drives `alu_b_sel`=11, `alu_a_sel`=0 and `alu_mode`=00. Every other output is 0 in decode. In every state, an output not named for that state is 0.
- R3: Operation 6'h23 (load) takes 5 cycles, in this order:
  - fetch
  - decode
  - address calculation: `alu_a_sel`=1, `alu_b_sel`=10
  - memory read: `mem_rd_en`=1, `mem_addr_sel`=1
  - write-back: `rf_wr_en`=1, `wb_from_mem`=1, `rf_dst_rd`=0

  After the write-back cycle the block returns to fetch.
- R4: Operation 6'h2B (store) takes 4 cycles: fetch, decode, address calculation, then memory write (`mem_wr_en`=1, `mem_addr_sel`=1). After the memory write the block returns to fetch.
- R5: Operation 6'h00 with a function field other than 6'h08 takes 4 cycles, in this order:
  - fetch
  - decode
  - execute: `alu_a_sel`=1, `alu_b_sel`=00, `alu_mode`=10
  - register write: `rf_wr_en`=1, `rf_dst_rd`=1, `wb_from_mem`=0

  After the register write the block returns to fetch.
- R6: Operation 6'h04 (branch) takes 3 cycles: fetch, decode, then branch completion. Branch completion drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_mode`=01, `pc_load_cond`=1 and `pc_src`=01.
- R7: Operation 6'h02 (jump) takes 3 cycles: fetch, decode, then jump completion with `pc_load`=1 and `pc_src`=10.
- R8: Operation 6'h00 with function 6'h08 (register jump) takes 3 cycles: fetch, decode, then register-jump completion with `pc_load`=1 and `pc_src`=11. This path takes priority over the generic R5 path.
- R9: Any other operation value goes from decode straight back to fetch, so the instruction takes 2 cycles.
- R10: The outputs depend only on the state. A change of `op_i` or `fn_i` outside the decode and address-calculation states does not change the outputs in that cycle. It also does not change the remaining path of the instruction.
- R11: `mem_rd_en` and `mem_wr_en` are never 1 together. `pc_load` and `pc_load_cond` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 6 | Operation field from the instruction register |
| fn_i | input | 6 | Function field from the instruction register |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr_sel | output | 1 | Memory address source: 0 = PC, 1 = ALU result register |
| ir_load | output | 1 | Instruction register load |
| rf_dst_rd | output | 1 | Destination register field: 1 = rd, 0 = rt |
| rf_wr_en | output | 1 | Register file write enable |
| wb_from_mem | output | 1 | Write-back data: 1 = memory data register, 0 = ALU result |
| alu_a_sel | output | 1 | ALU A input: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU B input: 00 register B, 01 constant 4, 10 sign-extended immediate, 11 shifted immediate |
| alu_mode | output | 2 | ALU mode: 00 add, 01 subtract, 10 use function field |
| pc_load | output | 1 | Unconditional PC load |
| pc_load_cond | output | 1 | PC load when the ALU reports zero |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target, 11 register value |

## Verification
The hardest situation to reach from the ports is the address-calculation state, the one point after decode where the operation field is read again. The stimulus drives that state only with load and store operations. It also runs an arithmetic instruction whose fields are changed to load-like and register-jump-like values after decode. This shows that only the decode and address states follow the inputs. A reset raised during a load's memory-read cycle covers the case where an instruction is abandoned. A function value next to the register-jump code checks that the priority decode is exact.

// File: rtl/multicycle_ctrl.sv
module multicycle_ctrl #(
  parameter int          OPW     = 6,
  parameter logic [5:0]  OP_LOAD = 6'h23,
  parameter logic [5:0]  OP_STOR = 6'h2B,
  parameter logic [5:0]  OP_ALU  = 6'h00,
  parameter logic [5:0]  OP_BEQ  = 6'h04,
  parameter logic [5:0]  OP_JMP  = 6'h02,
  parameter logic [5:0]  FN_JREG = 6'h08
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] op_i,
  input  logic [OPW-1:0] fn_i,
  output logic           mem_rd_en,
  output logic           mem_wr_en,
  output logic           mem_addr_sel,
  output logic           ir_load,
  output logic           rf_dst_rd,
  output logic           rf_wr_en,
  output logic           wb_from_mem,
  output logic           alu_a_sel,
  output logic [1:0]     alu_b_sel,
  output logic [1:0]     alu_mode,
  output logic           pc_load,
  output logic           pc_load_cond,
  output logic [1:0]     pc_src
);

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_ADDR, ST_LDMEM, ST_LDWB, ST_STMEM,
    ST_EXEC, ST_RWB, ST_BRANCH, ST_JUMP, ST_JREG
  } state_t;

  state_t state, state_nx;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= state_nx;
  end

  always_comb begin
    state_nx = ST_FETCH;
    unique case (state)
      ST_FETCH:  state_nx = ST_DECODE;
      ST_DECODE: begin
        if (op_i == OP_LOAD || op_i == OP_STOR)  state_nx = ST_ADDR;
        else if (op_i == OP_ALU)                 state_nx = (fn_i == FN_JREG) ? ST_JREG : ST_EXEC;
        else if (op_i == OP_BEQ)                 state_nx = ST_BRANCH;
        else if (op_i == OP_JMP)                 state_nx = ST_JUMP;
        else                                     state_nx = ST_FETCH;
      end
      ST_ADDR:   state_nx = (op_i == OP_STOR) ? ST_STMEM : ST_LDMEM;
      ST_LDMEM:  state_nx = ST_LDWB;
      ST_EXEC:   state_nx = ST_RWB;
      default:   state_nx = ST_FETCH;
    endcase
  end

  assign mem_rd_en    = (state == ST_FETCH) || (state == ST_LDMEM);
  assign mem_wr_en    = (state == ST_STMEM);
  assign mem_addr_sel = (state == ST_LDMEM) || (state == ST_STMEM);
  assign ir_load      = (state == ST_FETCH);
  assign rf_dst_rd    = (state == ST_RWB);
  assign rf_wr_en     = (state == ST_LDWB) || (state == ST_RWB);
  assign wb_from_mem  = (state == ST_LDWB);
  assign alu_a_sel    = (state == ST_ADDR) || (state == ST_EXEC) || (state == ST_BRANCH);
  assign alu_b_sel    = (state == ST_FETCH)  ? 2'b01 :
                        (state == ST_DECODE) ? 2'b11 :
                        (state == ST_ADDR)   ? 2'b10 : 2'b00;
  assign alu_mode     = (state == ST_EXEC)   ? 2'b10 :
                        (state == ST_BRANCH) ? 2'b01 : 2'b00;
  assign pc_load      = (state == ST_FETCH) || (state == ST_JUMP) || (state == ST_JREG);
  assign pc_load_cond = (state == ST_BRANCH);
  assign pc_src       = (state == ST_BRANCH) ? 2'b01 :
                        (state == ST_JUMP)   ? 2'b10 :
                        (state == ST_JREG)   ? 2'b11 : 2'b00;

  p_fetch_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ir_load && mem_rd_en && pc_load && !mem_addr_sel));

  p_decode_follows_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    ir_load |=> (alu_b_sel == 2'b11 && !pc_load && !mem_rd_en));

  p_load_writeback_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && mem_addr_sel) |=> (rf_wr_en && wb_from_mem && !rf_dst_rd));

  p_store_returns_r4: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |=> ir_load);

  p_exec_then_write_r5: assert property (@(posedge clk) disable iff (rst)
    (alu_mode == 2'b10) |=> (rf_wr_en && rf_dst_rd && !wb_from_mem));

  p_branch_returns_r6: assert property (@(posedge clk) disable iff (rst)
    pc_load_cond |=> ir_load);

  p_jreg_target_r8: assert property (@(posedge clk) disable iff (rst)
    (alu_b_sel == 2'b11 && op_i == OP_ALU && fn_i == FN_JREG) |=> (pc_load && pc_src == 2'b11));

  p_strobes_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en) && !(pc_load && pc_load_cond));

endmodule

// File: tb/tb_multicycle_ctrl.sv
module tb_multicycle_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] op  = 6'h00;
  logic [5:0] fn  = 6'h00;
  logic mem_rd_en, mem_wr_en, mem_addr_sel, ir_load, rf_dst_rd, rf_wr_en;
  logic wb_from_mem, alu_a_sel, pc_load, pc_load_cond;
  logic [1:0] alu_b_sel, alu_mode, pc_src;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  multicycle_ctrl dut (
    .clk(clk), .rst(rst), .op_i(op), .fn_i(fn),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr_sel(mem_addr_sel),
    .ir_load(ir_load), .rf_dst_rd(rf_dst_rd), .rf_wr_en(rf_wr_en),
    .wb_from_mem(wb_from_mem), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
    .alu_mode(alu_mode), .pc_load(pc_load), .pc_load_cond(pc_load_cond), .pc_src(pc_src)
  );

  wire [15:0] obs = {mem_rd_en, mem_wr_en, mem_addr_sel, ir_load, rf_dst_rd, rf_wr_en,
                     wb_from_mem, alu_a_sel, alu_b_sel, alu_mode, pc_load, pc_load_cond, pc_src};

  function automatic logic [15:0] v(input bit rd, wr, ad, il, ds, rw, wm, a,
                                    input bit [1:0] b, m, input bit pl, pz, input bit [1:0] ps);
    return {rd, wr, ad, il, ds, rw, wm, a, b, m, pl, pz, ps};
  endfunction

  localparam logic [15:0] E_FETCH  = {1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'b01,2'b00,1'b1,1'b0,2'b00};
  localparam logic [15:0] E_DECODE = {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b11,2'b00,1'b0,1'b0,2'b00};

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input logic [15:0] exp, input string req);
    checks++;
    if (obs !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, obs, exp);
    end
  endtask

  task automatic chk_excl(input string req);
    checks++;
    if ((mem_rd_en && mem_wr_en) || (pc_load && pc_load_cond)) begin
      fails++;
      $display("FAIL %s actual=%b%b%b%b expected=no overlapping strobes", req,
               mem_rd_en, mem_wr_en, pc_load, pc_load_cond);
    end
  endtask

  task automatic t_reset_r1();
    rst = 1'b1; step(); chk(E_FETCH, "R1 held reset");
    rst = 1'b0; #1;     chk(E_FETCH, "R1 after release");
  endtask

  task automatic t_load_r3();
    op = 6'h23; fn = 6'h00;
    chk(E_FETCH, "R3 fetch"); chk_excl("R11 fetch");
    step(); chk(E_DECODE, "R2 decode");
    step(); chk(v(0,0,0,0,0,0,0,1,2'b10,2'b00,0,0,2'b00), "R3 address");
    step(); chk(v(1,0,1,0,0,0,0,0,2'b00,2'b00,0,0,2'b00), "R3 mem read");
    step(); chk(v(0,0,0,0,0,1,1,0,2'b00,2'b00,0,0,2'b00), "R3 writeback");
    step(); chk(E_FETCH, "R3 return to fetch after 5 cycles");
  endtask

  task automatic t_store_r4();
    op = 6'h2B;
    step(); chk(E_DECODE, "R4 decode");
    step(); chk(v(0,0,0,0,0,0,0,1,2'b10,2'b00,0,0,2'b00), "R4 address");
    step(); chk(v(0,1,1,0,0,0,0,0,2'b00,2'b00,0,0,2'b00), "R4 mem write");
    chk_excl("R11 store");
    step(); chk(E_FETCH, "R4 return to fetch after 4 cycles");
  endtask

  task automatic t_rtype_r5(input logic [5:0] f);
    op = 6'h00; fn = f;
    step(); chk(E_DECODE, "R5 decode");
    step(); chk(v(0,0,0,0,0,0,0,1,2'b00,2'b10,0,0,2'b00), "R5 execute");
    step(); chk(v(0,0,0,0,1,1,0,0,2'b00,2'b00,0,0,2'b00), "R5 register write");
    step(); chk(E_FETCH, "R5 return to fetch after 4 cycles");
  endtask

  task automatic t_branch_r6();
    op = 6'h04;
    step(); chk(E_DECODE, "R6 decode");
    step(); chk(v(0,0,0,0,0,0,0,1,2'b00,2'b01,0,1,2'b01), "R6 branch completion");
    chk_excl("R11 branch");
    step(); chk(E_FETCH, "R6 return to fetch after 3 cycles");
  endtask

  task automatic t_jump_r7();
    op = 6'h02;
    step(); chk(E_DECODE, "R7 decode");
    step(); chk(v(0,0,0,0,0,0,0,0,2'b00,2'b00,1,0,2'b10), "R7 jump completion");
    step(); chk(E_FETCH, "R7 return to fetch after 3 cycles");
  endtask

  task automatic t_jreg_r8();
    op = 6'h00; fn = 6'h08;
    step(); chk(E_DECODE, "R8 decode");
    step(); chk(v(0,0,0,0,0,0,0,0,2'b00,2'b00,1,0,2'b11), "R8 register jump completion");
    step(); chk(E_FETCH, "R8 return to fetch after 3 cycles");
  endtask

  task automatic t_unknown_r9();
    op = 6'h3F;
    step(); chk(E_DECODE, "R9 decode");
    step(); chk(E_FETCH, "R9 unknown op returns to fetch");
  endtask

  task automatic t_moore_r10();
    op = 6'h00; fn = 6'h20;
    step(); chk(E_DECODE, "R10 decode");
    step(); chk(v(0,0,0,0,0,0,0,1,2'b00,2'b10,0,0,2'b00), "R10 execute");
    op = 6'h23; fn = 6'h08; #1;
    chk(v(0,0,0,0,0,0,0,1,2'b00,2'b10,0,0,2'b00), "R10 outputs unchanged by field change");
    step(); chk(v(0,0,0,0,1,1,0,0,2'b00,2'b00,0,0,2'b00), "R10 path unchanged");
    step(); chk(E_FETCH, "R10 back to fetch");
  endtask

  task automatic t_mid_reset_r1();
    op = 6'h23;
    step(); step(); step();
    chk(v(1,0,1,0,0,0,0,0,2'b00,2'b00,0,0,2'b00), "R1 reached mem read");
    rst = 1'b1; step(); chk(E_FETCH, "R1 reset mid-instruction");
    rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1;
    step(); step();
    t_reset_r1();
    t_load_r3();
    t_store_r4();
    t_rtype_r5(6'h20);
    t_rtype_r5(6'h09);
    t_branch_r6();
    t_jump_r7();
    t_jreg_r8();
    t_unknown_r9();
    t_moore_r10();
    t_mid_reset_r1();
    t_jreg_r8();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule